// File: doc/BRIEF.md
# Oscillator Slew-Rate Calibration Sequencer

This block calibrates the slew-rate control code of a high-speed transmitter without software. It is started with a one-cycle `start` pulse. It powers up an on-chip ring oscillator and lets it settle, then opens a clock gate that passes the oscillator clock into the block. Next it arms a frequency meter. The meter counts reference-clock cycles across a fixed window of oscillator periods. The meter is polled at a fixed interval and abandoned after a fixed number of polls. Once the measurement is over, the block turns the meter off and then the clock gate.

From the measured count the block computes a code. The first step is the quotient of reference frequency (MHz) × coefficient × window length over the count. That quotient is then divided by a divisor, rounding to the nearest integer. If no count was obtained, a fixed default code is used instead. The code is written to the slew output while the oscillator is still powered, and only after that is the oscillator switched off. A nonzero `force_code` at start skips the whole sequence and leaves the existing code in place.

The oscillator clock is treated as asynchronous. It passes through a two-flop synchronizer, and its rising edges are detected in the `clk` domain. Both divides share one multi-cycle restoring divider.

Top module: `srcal_ctrl`

## Requirements
- R1: After synchronous active-low reset, `slew_code` is 0 and `osc_en`, `gate_en`, `meter_en` and `done` are all 0.
- R2: A `start` seen while idle with `force_code` nonzero raises `done` on the next cycle. In that case `osc_en` never rises and `slew_code` keeps its value.
- R3: A normal start raises `osc_en` on the next cycle. `gate_en` rises SETTLE_CYC cycles after `osc_en`, and `meter_en` rises one cycle after `gate_en`. `meter_en` is never high without `gate_en`, and `gate_en` is never high without `osc_en`.
- R4: The count is the number of `clk` cycles from one synchronized rising edge of the oscillator clock to the edge 2^WIN_LOG2 periods later. The meter is checked every POLL_CYC cycles. It is abandoned after POLL_MAX checks, which gives a count of 0, and the block carries on without any error indication.
- R5: At the end of a measurement, `meter_en` falls first and `gate_en` falls exactly one cycle later.
- R6: For a nonzero count C, the code is q1 = floor(ref_mhz × coef × 2^WIN_LOG2 / C), followed by floor((q1 + DIVISOR/2) / DIVISOR).
- R7: A computed code above 7, the largest value of the 3-bit field, is written as 7.
- R8: A zero count, whether from a timeout or from an oscillator that never toggles, writes the default code 3.
- R9: `slew_code` only changes while `osc_en` is high. `osc_en` falls one cycle after the write.
- R10: `done` is high for exactly one cycle per finished or skipped sequence.
- R11: A `start` that arrives while a sequence is running is ignored. It produces no second `done`, no new oscillator enable, and no change to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run or skip calibration |
| force_code | input | CODE_W | Nonzero value skips calibration |
| ref_mhz | input | REF_W | Reference clock frequency in MHz, latched at start |
| coef | input | COEF_W | Calibration coefficient, latched at start |
| osc_clk | input | 1 | Ring-oscillator clock (asynchronous) |
| osc_en | output | 1 | Ring-oscillator power enable |
| gate_en | output | 1 | Oscillator clock gate enable |
| meter_en | output | 1 | Frequency meter enable |
| slew_code | output | CODE_W | Transmitter slew-rate control code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `osc_clk` only toggles while `osc_en` and `gate_en` are both high, and that it holds steady long enough for the synchronizer to catch every level. The bench models the oscillator as a divided copy of `clk`: it toggles every H cycles at the falling edge, and only while both enables are up, so the spacing between edges is exact and the expected count is 2^WIN_LOG2 × 2H. `force_code`, `ref_mhz` and `coef` change only while the block is idle. This keeps the latched operands and the bypass decision within what the properties expect.

// File: rtl/srcal_pkg.sv
// Package: shared state encoding for the slew-rate calibration sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package srcal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_GATE,
        ST_MEAS,
        ST_DET_OFF,
        ST_CLK_OFF,
        ST_DIV1_GO,
        ST_DIV1_WAIT,
        ST_DIV2_GO,
        ST_DIV2_WAIT,
        ST_WRITE,
        ST_OFF
    } state_t;

endpackage

// File: rtl/srcal_osc_meter.sv
// Module: srcal_osc_meter
// Brings the oscillator clock into the clk domain (two flops plus an edge
// register) and counts clk cycles between the first detected rising edge and
// the edge 2^WIN_LOG2 periods later. Raises valid once the window closes.
// Assumes: osc_clk high and low phases each last at least one clk period;
// all state clears while enable is low.
module srcal_osc_meter #(
    parameter int WIN_LOG2 = 10,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             osc_clk,
    output logic             valid,
    output logic [CNT_W-1:0] count
);
    localparam logic [WIN_LOG2-1:0] LAST_EDGE = '1;

    logic             sync1, sync2, sync3;
    logic             started;
    logic [WIN_LOG2-1:0] edges;
    logic             rise;

    // Purpose: synchronize the oscillator clock and keep its previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= osc_clk;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    assign rise = sync2 & ~sync3;

    // Purpose: count reference cycles across the window of oscillator periods.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            started <= 1'b0;
            edges   <= '0;
            valid   <= 1'b0;
            count   <= '0;
        end else if (!valid) begin
            if (started && count != '1) begin
                count <= count + 1'b1;
            end
            if (rise) begin
                if (!started) begin
                    started <= 1'b1;
                    count   <= '0;
                end else begin
                    edges <= edges + 1'b1;
                    if (edges == LAST_EDGE) begin
                        valid <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/srcal_divider.sv
// Module: srcal_divider
// Unsigned restoring divider: one quotient bit per cycle, W cycles per divide.
// The quotient stays on quo until the next start.
// Assumes: den is nonzero; start is only pulsed while busy is low.
module srcal_divider #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         fin,
    output logic [W-1:0] quo
);
    localparam int IW = $clog2(W + 1);

    logic [W:0]    rem;
    logic [W-1:0]  den_q;
    logic [IW-1:0] iter;
    logic [W:0]    trial;

    assign trial = {rem[W-1:0], quo[W-1]};

    // Purpose: shift in one dividend bit per cycle and restore on underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            den_q <= '0;
            quo   <= '0;
            iter  <= '0;
            busy  <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start && !busy) begin
                rem   <= '0;
                den_q <= den;
                quo   <= num;
                iter  <= IW'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, den_q}) begin
                    rem <= trial - {1'b0, den_q};
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= trial;
                    quo <= {quo[W-2:0], 1'b0};
                end
                iter <= iter - 1'b1;
                if (iter == IW'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/srcal_ctrl.sv
// Module: srcal_ctrl (top)
// Sequences the slew-rate calibration in this order: power the oscillator,
// wait for it to settle, open the clock gate, arm the meter, poll it, close
// the meter and then the gate, divide twice with rounding, write the code,
// and power the oscillator down. A nonzero force_code skips everything.
// Assumes: force_code, ref_mhz and coef are stable at start; DIVISOR > 0.
module srcal_ctrl #(
    parameter int REF_W      = 10,
    parameter int COEF_W     = 8,
    parameter int CODE_W     = 3,
    parameter int WIN_LOG2   = 10,
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 250,
    parameter int POLL_CYC   = 2500,
    parameter int POLL_MAX   = 20,
    parameter int DIVISOR    = 1000,
    parameter int DEF_CODE   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] force_code,
    input  logic [REF_W-1:0]  ref_mhz,
    input  logic [COEF_W-1:0] coef,
    input  logic              osc_clk,
    output logic              osc_en,
    output logic              gate_en,
    output logic              meter_en,
    output logic [CODE_W-1:0] slew_code,
    output logic              done
);
    import srcal_pkg::*;

    localparam int DW     = REF_W + COEF_W + WIN_LOG2 + 1;
    localparam int TMAX   = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
    localparam int TMR_W  = $clog2(TMAX + 1);
    localparam int PCNT_W = $clog2(POLL_MAX + 1);
    localparam logic [DW-1:0]     HALF_DIV = DW'(DIVISOR / 2);
    localparam logic [DW-1:0]     DIV_V    = DW'(DIVISOR);
    localparam logic [DW-1:0]     MAX_CODE = DW'((1 << CODE_W) - 1);
    localparam logic [CODE_W-1:0] DEF_V    = CODE_W'(DEF_CODE);

    state_t              st;
    logic [TMR_W-1:0]    tmr;
    logic [PCNT_W-1:0]   polls;
    logic [REF_W-1:0]    ref_q;
    logic [COEF_W-1:0]   coef_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                zero_q;
    logic                m_valid;
    logic [CNT_W-1:0]    m_count;
    logic                div_start;
    logic [DW-1:0]       div_num;
    logic [DW-1:0]       div_den;
    logic                div_busy;
    logic                div_fin;
    logic [DW-1:0]       div_quo;
    logic [DW-1:0]       product;

    srcal_osc_meter #(
        .WIN_LOG2 (WIN_LOG2),
        .CNT_W    (CNT_W)
    ) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (meter_en),
        .osc_clk (osc_clk),
        .valid   (m_valid),
        .count   (m_count)
    );

    srcal_divider #(
        .W (DW)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .busy  (div_busy),
        .fin   (div_fin),
        .quo   (div_quo)
    );

    // Purpose: decode the analog enables from the sequencer state.
    always_comb begin
        osc_en   = (st != ST_IDLE);
        gate_en  = (st == ST_GATE) || (st == ST_MEAS) || (st == ST_DET_OFF);
        meter_en = (st == ST_MEAS);
    end

    // Purpose: choose the operands of the shared divider for each divide step.
    always_comb begin
        product   = (DW'(ref_q) * DW'(coef_q)) << WIN_LOG2;
        div_start = (st == ST_DIV1_GO) || (st == ST_DIV2_GO);
        if (st == ST_DIV2_GO) begin
            div_num = div_quo + HALF_DIV;
            div_den = DIV_V;
        end else begin
            div_num = product;
            div_den = DW'(cnt_q);
        end
    end

    // Purpose: main sequencer with its settle and poll timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            tmr       <= '0;
            polls     <= '0;
            ref_q     <= '0;
            coef_q    <= '0;
            cnt_q     <= '0;
            zero_q    <= 1'b0;
            slew_code <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (force_code != '0) begin
                            done <= 1'b1;
                        end else begin
                            ref_q  <= ref_mhz;
                            coef_q <= coef;
                            tmr    <= '0;
                            st     <= ST_SETTLE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tmr == TMR_W'(SETTLE_CYC - 1)) begin
                        tmr <= '0;
                        st  <= ST_GATE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_GATE: begin
                    tmr   <= '0;
                    polls <= '0;
                    st    <= ST_MEAS;
                end
                ST_MEAS: begin
                    if (tmr == TMR_W'(POLL_CYC - 1)) begin
                        tmr <= '0;
                        if (m_valid) begin
                            cnt_q  <= m_count;
                            zero_q <= (m_count == '0);
                            st     <= ST_DET_OFF;
                        end else if (polls == PCNT_W'(POLL_MAX - 1)) begin
                            cnt_q  <= '0;
                            zero_q <= 1'b1;
                            st     <= ST_DET_OFF;
                        end else begin
                            polls <= polls + 1'b1;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_DET_OFF:   st <= ST_CLK_OFF;
                ST_CLK_OFF:   st <= zero_q ? ST_WRITE : ST_DIV1_GO;
                ST_DIV1_GO:   st <= ST_DIV1_WAIT;
                ST_DIV1_WAIT: if (div_fin) st <= ST_DIV2_GO;
                ST_DIV2_GO:   st <= ST_DIV2_WAIT;
                ST_DIV2_WAIT: if (div_fin) st <= ST_WRITE;
                ST_WRITE: begin
                    if (zero_q) begin
                        slew_code <= DEF_V;
                    end else if (div_quo > MAX_CODE) begin
                        slew_code <= MAX_CODE[CODE_W-1:0];
                    end else begin
                        slew_code <= div_quo[CODE_W-1:0];
                    end
                    st <= ST_OFF;
                end
                ST_OFF: begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/srcal_ctrl_chk.sv
// Module: srcal_ctrl_chk
// Property checker for srcal_ctrl, attached with bind below.
// Assumes: it watches the top-level ports and the sequencer state.
module srcal_ctrl_chk #(
    parameter int CODE_W   = 3,
    parameter int POLL_CYC = 2500,
    parameter int POLL_MAX = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [CODE_W-1:0]  force_code,
    input logic               osc_en,
    input logic               gate_en,
    input logic               meter_en,
    input logic [CODE_W-1:0]  slew_code,
    input logic               done,
    input srcal_pkg::state_t  st
);
    import srcal_pkg::*;

    localparam int MEAS_LIMIT = POLL_CYC * POLL_MAX;

    int meas_cycles;

    // Purpose: count consecutive cycles with the meter armed.
    always_ff @(posedge clk) begin
        if (!rst_n || !meter_en) meas_cycles <= 0;
        else                     meas_cycles <= meas_cycles + 1;
    end

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start && force_code != '0) |=> (done && !osc_en && $stable(slew_code))); // R2
    AST_GATE_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |-> osc_en); // R3
    AST_METER_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        meter_en |-> gate_en); // R3
    AST_MEAS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        meter_en |-> (meas_cycles < MEAS_LIMIT)); // R4
    AST_DET_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_en) |-> !$past(meter_en)); // R5
    AST_WRITE_WHILE_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(slew_code) |-> osc_en); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

bind srcal_ctrl srcal_ctrl_chk #(
    .CODE_W   (CODE_W),
    .POLL_CYC (POLL_CYC),
    .POLL_MAX (POLL_MAX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .force_code (force_code),
    .osc_en     (osc_en),
    .gate_en    (gate_en),
    .meter_en   (meter_en),
    .slew_code  (slew_code),
    .done       (done),
    .st         (st)
);

// File: tb/srcal_ctrl_test.sv
module srcal_ctrl_test;
    localparam int WL     = 4;
    localparam int WIN    = 1 << WL;
    localparam int SETTLE = 8;
    localparam int PCYC   = 64;
    localparam int PMAX   = 20;
    localparam int DIVV   = 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] force_code = '0;
    logic [9:0] ref_mhz = '0;
    logic [7:0] coef = '0;
    logic       osc_clk = 1'b0;
    logic       osc_en, gate_en, meter_en, done;
    logic [2:0] slew_code;

    int osc_half = 0;
    int hc = 0;
    int total = 0;
    int fails = 0;
    int cycles = 0;

    srcal_ctrl #(
        .WIN_LOG2 (WL), .SETTLE_CYC (SETTLE), .POLL_CYC (PCYC),
        .POLL_MAX (PMAX), .DIVISOR (DIVV)
    ) uut (
        .clk (clk), .rst_n (rst_n), .start (start), .force_code (force_code),
        .ref_mhz (ref_mhz), .coef (coef), .osc_clk (osc_clk),
        .osc_en (osc_en), .gate_en (gate_en), .meter_en (meter_en),
        .slew_code (slew_code), .done (done)
    );

    always #2 clk = ~clk;

    // Oscillator model: toggles every osc_half cycles only while powered and gated.
    always @(negedge clk) begin
        if (osc_en && gate_en && osc_half > 0) begin
            if (hc == osc_half - 1) begin
                hc <= 0;
                osc_clk <= ~osc_clk;
            end else begin
                hc <= hc + 1;
            end
        end else begin
            hc <= 0;
            osc_clk <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            fails++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic int exp_code(input int r, input int c, input int h);
        int cnt, q1, k;
        if (h == 0 || WIN * 2 * h + 8 > PCYC * PMAX) return 3;
        cnt = WIN * 2 * h;
        q1 = (r * c * WIN) / cnt;
        k = (q1 + DIVV / 2) / DIVV;
        return (k > 7) ? 7 : k;
    endfunction

    // Runs one calibration and checks order, timing, the single done and the code.
    task automatic run_cal(input int r, input int c, input int h, input bit poke);
        int cyc = 0, t_osc = -1, t_gate = -1, t_met = -1;
        int t_met_off = -1, t_gate_off = -1, ndone = 0, e;
        bit pm = 0, pg = 0;
        ref_mhz = 10'(r); coef = 8'(c); osc_half = h;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!done && cyc < 6000) begin
            if (osc_en && t_osc < 0) t_osc = cyc;
            if (gate_en && t_gate < 0) t_gate = cyc;
            if (meter_en && t_met < 0) t_met = cyc;
            if (pm && !meter_en && t_met_off < 0) t_met_off = cyc;
            if (pg && !gate_en && t_gate_off < 0) t_gate_off = cyc;
            pm = meter_en; pg = gate_en;
            start = poke && (cyc == 30 || cyc == SETTLE + 5);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        if (done) ndone++;
        chk(t_osc == 1, "R3 osc_en rise", t_osc, 1);
        chk(t_gate - t_osc == SETTLE, "R3 settle gap", t_gate - t_osc, SETTLE);
        chk(t_met - t_gate == 1, "R3 meter after gate", t_met - t_gate, 1);
        chk(t_gate_off - t_met_off == 1, "R5 shutdown order", t_gate_off - t_met_off, 1);
        chk(!osc_en, "R9 osc off at done", osc_en, 0);
        e = exp_code(r, c, h);
        if (e == 3 && (h == 0 || WIN * 2 * h + 8 > PCYC * PMAX))
            chk(slew_code == 3, "R8 default code", slew_code, 3);
        else
            chk(int'(slew_code) == e, "R6 R7 code", slew_code, e);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done) ndone++;
            if (osc_en) chk(0, "R11 restarted", 1, 0);
        end
        chk(ndone == 1, "R10 R11 single done", ndone, 1);
    endtask

    initial begin
        int keep;
        int refs[5] = '{20, 100, 250, 500, 1000};
        int coefs[4] = '{1, 17, 64, 200};
        repeat (5) @(negedge clk);
        chk(slew_code == 0, "R1 slew reset", slew_code, 0);
        chk(!osc_en && !gate_en && !meter_en && !done, "R1 outputs reset",
            {osc_en, gate_en, meter_en, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 R7 sweep across reference, coefficient and oscillator period
        for (int a = 0; a < 5; a++)
            for (int b = 0; b < 4; b++)
                for (int h = 1; h <= 4; h++)
                    run_cal(refs[a] > 1023 ? 1023 : refs[a], coefs[b], h, 0);
        // R7 saturation with a fast oscillator and large operands
        run_cal(1000, 255, 1, 0);
        // R8 silent oscillator and an oscillator too slow for the timeout (R4)
        run_cal(250, 17, 0, 0);
        run_cal(250, 17, 60, 0);
        // R11 start pulses while busy
        run_cal(500, 64, 2, 1);
        // R2 bypass keeps the code
        keep = slew_code;
        force_code = 3'd5;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1, "R2 bypass done", done, 1);
        chk(!osc_en, "R2 no oscillator", osc_en, 0);
        repeat (10) begin
            @(negedge clk);
            if (osc_en || done) chk(0, "R2 bypass quiet", 1, 0);
        end
        chk(int'(slew_code) == keep, "R2 code untouched", slew_code, keep);
        force_code = '0;
        run_cal(1000, 100, 3, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule